// File: doc/BRIEF.md
# Paired-Coordinate Consistency Averager

This block sits behind a resistive touch panel's scan sequencer. Each scan frame carries two readings per axis: one taken with the plate driven in one direction and one with it driven in the other. It also carries two pressure readings. When the two readings of an axis agree, the touch was stable during the scan. The block then reports the mean of the pair as the coordinate. When the readings disagree, the frame is discarded as noise.

The X axis is judged first. A frame whose X pair disagrees is rejected on that basis alone, whatever the Y pair holds. A frame that passes both axes yields one registered point strobe with the averaged X and Y. The two pressure readings travel unchanged beside the point. Each discarded frame advances a saturating drop counter. The allowed scatter comes from a threshold input that may change between frames.

Top module: `touch_pair_avg`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `pt_vld` is 0, `drop_cnt` is 0 and the point outputs are 0.
- R2: A frame accepted on a clock edge with `frame_vld` high raises `pt_vld` for exactly the following cycle. In that cycle `pt_x` = (`rd_xm` + `rd_xp`) >> 1 and `pt_y` = (`rd_ym` + `rd_yp`) >> 1.
- R3: An axis fails when its larger reading exceeds its smaller reading plus `scatter_thr`. A difference exactly equal to `scatter_thr` passes.
- R4: Two equal readings on an axis always pass, including when `scatter_thr` is 0.
- R5: A frame in which either axis fails produces no `pt_vld`.
- R6: A frame whose X pair fails is rejected and counted once, whether its Y pair passes or fails.
- R7: With an accepted point, `pt_za` and `pt_zb` carry the `rd_za` and `rd_zb` values of that frame.
- R8: Each rejected frame raises `drop_cnt` (16 bits) by one. At 65535 it holds.
- R9: In a cycle after `frame_vld` was low, `pt_vld` is 0 and `pt_x`, `pt_y`, `pt_za` and `pt_zb` keep their values.
- R10: The mean is formed from a 13-bit sum, so the full-scale readings 4095 and 4095 give 4095, and 4095 and 4094 give 4094.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | A scan frame is present on the reading inputs |
| rd_xm | input | 12 | X reading, minus-direction drive |
| rd_xp | input | 12 | X reading, plus-direction drive |
| rd_ym | input | 12 | Y reading, minus-direction drive |
| rd_yp | input | 12 | Y reading, plus-direction drive |
| rd_za | input | 12 | First pressure reading |
| rd_zb | input | 12 | Second pressure reading |
| scatter_thr | input | 12 | Largest allowed difference within a pair |
| pt_vld | output | 1 | Point strobe, one cycle per accepted frame |
| pt_x | output | 12 | Averaged X coordinate |
| pt_y | output | 12 | Averaged Y coordinate |
| pt_za | output | 12 | Forwarded first pressure reading |
| pt_zb | output | 12 | Forwarded second pressure reading |
| drop_cnt | output | 16 | Saturating count of rejected frames |

## Verification
The hardest condition to reach from the ports is the counter at its ceiling. It needs 65535 rejected frames before the hold behaviour can show. The stimulus streams back-to-back frames with a wide X scatter and a zero threshold until the count passes the ceiling by a few frames. The scoreboard tracks the expected count on every frame. The threshold edges are reached with pairs that differ by exactly the threshold and by one more. The X-first ordering is reached with frames that fail X while Y passes, and with frames that fail both axes, each of which must add one drop and no point.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
   localparam int unsigned N_AXES = 2;
   localparam int unsigned AX_X = 0;
   localparam int unsigned AX_Y = 1;

   typedef enum logic [1:0] {
      VD_ACCEPT = 2'd0,
      VD_REJ_X  = 2'd1,
      VD_REJ_Y  = 2'd2
   } verdict_e;
endpackage

// File: rtl/tpa_axis_unit.sv
module tpa_axis_unit #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned THR_W  = 12
) (
   input  logic [DATA_W-1:0] rd_m,
   input  logic [DATA_W-1:0] rd_p,
   input  logic [THR_W-1:0]  thr,
   output logic              far,
   output logic [DATA_W-1:0] mean
);
   localparam int unsigned SUM_W = DATA_W + 1;

   logic [DATA_W-1:0] hi_rd;
   logic [DATA_W-1:0] lo_rd;
   logic [SUM_W-1:0]  lo_ext;
   logic [SUM_W-1:0]  hi_ext;
   logic [SUM_W-1:0]  limit;
   logic [SUM_W-1:0]  pair_sum;

   always_comb begin
      if (rd_p > rd_m) begin
         hi_rd = rd_p;
         lo_rd = rd_m;
      end else begin
         hi_rd = rd_m;
         lo_rd = rd_p;
      end
      lo_ext   = {1'b0, lo_rd};
      hi_ext   = {1'b0, hi_rd};
      limit    = lo_ext + SUM_W'(thr);
      far      = hi_ext > limit;
      pair_sum = {1'b0, rd_m} + {1'b0, rd_p};
      mean     = pair_sum[SUM_W-1:1];
   end
endmodule

// File: rtl/tpa_verdict.sv
module tpa_verdict
   import tpa_pkg::*;
(
   input  logic [N_AXES-1:0] far_vec,
   output verdict_e          verdict
);
   always_comb begin
      if (far_vec[AX_X])      verdict = VD_REJ_X;
      else if (far_vec[AX_Y]) verdict = VD_REJ_Y;
      else                    verdict = VD_ACCEPT;
   end
endmodule

// File: rtl/tpa_event_counter.sv
module tpa_event_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic step_ok;

   generate
      if (SATURATE) begin : g_sat
         assign step_ok = inc && (count != CNT_MAX);
      end else begin : g_wrap
         assign step_ok = inc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (step_ok) count <= count + 1'b1;
   end
endmodule

// File: rtl/touch_pair_avg.sv
module touch_pair_avg
   import tpa_pkg::*;
#(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned THR_W  = 12,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_vld,
   input  logic [DATA_W-1:0] rd_xm,
   input  logic [DATA_W-1:0] rd_xp,
   input  logic [DATA_W-1:0] rd_ym,
   input  logic [DATA_W-1:0] rd_yp,
   input  logic [DATA_W-1:0] rd_za,
   input  logic [DATA_W-1:0] rd_zb,
   input  logic [THR_W-1:0]  scatter_thr,
   output logic              pt_vld,
   output logic [DATA_W-1:0] pt_x,
   output logic [DATA_W-1:0] pt_y,
   output logic [DATA_W-1:0] pt_za,
   output logic [DATA_W-1:0] pt_zb,
   output logic [CNT_W-1:0]  drop_cnt
);
   initial begin
      assert (THR_W <= DATA_W) else $error("THR_W must not exceed DATA_W");
      assert (DATA_W >= 2)     else $error("DATA_W too small");
      assert (CNT_W >= 1)      else $error("CNT_W must be positive");
   end

   logic [DATA_W-1:0] rd_m_arr [N_AXES];
   logic [DATA_W-1:0] rd_p_arr [N_AXES];
   logic [DATA_W-1:0] mean_arr [N_AXES];
   logic [N_AXES-1:0] far_vec;
   verdict_e          verdict;
   logic              accept;
   logic              reject;
   logic              far_x;
   logic              far_y;

   assign rd_m_arr[AX_X] = rd_xm;
   assign rd_p_arr[AX_X] = rd_xp;
   assign rd_m_arr[AX_Y] = rd_ym;
   assign rd_p_arr[AX_Y] = rd_yp;

   generate
      for (genvar a = 0; a < N_AXES; a++) begin : g_axis
         tpa_axis_unit #(
            .DATA_W (DATA_W),
            .THR_W  (THR_W)
         ) i_axis (
            .rd_m (rd_m_arr[a]),
            .rd_p (rd_p_arr[a]),
            .thr  (scatter_thr),
            .far  (far_vec[a]),
            .mean (mean_arr[a])
         );
      end
   endgenerate

   assign far_x = far_vec[AX_X];
   assign far_y = far_vec[AX_Y];

   tpa_verdict i_verdict (
      .far_vec (far_vec),
      .verdict (verdict)
   );

   assign accept = frame_vld && (verdict == VD_ACCEPT);
   assign reject = frame_vld && (verdict != VD_ACCEPT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pt_vld <= 1'b0;
         pt_x   <= '0;
         pt_y   <= '0;
         pt_za  <= '0;
         pt_zb  <= '0;
      end else begin
         pt_vld <= accept;
         if (accept) begin
            pt_x  <= mean_arr[AX_X];
            pt_y  <= mean_arr[AX_Y];
            pt_za <= rd_za;
            pt_zb <= rd_zb;
         end
      end
   end

   tpa_event_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (1'b1)
   ) i_drop_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (reject),
      .count (drop_cnt)
   );
endmodule

// File: rtl/tpa_checker.sv
module tpa_checker #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_vld,
   input logic [DATA_W-1:0] rd_xm,
   input logic [DATA_W-1:0] rd_xp,
   input logic [DATA_W-1:0] rd_ym,
   input logic [DATA_W-1:0] rd_yp,
   input logic [DATA_W-1:0] rd_za,
   input logic              far_x,
   input logic              far_y,
   input logic              pt_vld,
   input logic [DATA_W-1:0] pt_x,
   input logic [DATA_W-1:0] pt_y,
   input logic [DATA_W-1:0] pt_za,
   input logic [CNT_W-1:0]  drop_cnt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [DATA_W:0] sum_x_chk;
   logic [DATA_W:0] sum_y_chk;
   assign sum_x_chk = {1'b0, rd_xm} + {1'b0, rd_xp};
   assign sum_y_chk = {1'b0, rd_ym} + {1'b0, rd_yp};

   p_strobe_needs_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pt_vld |-> $past(frame_vld));
   p_mean_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pt_vld |-> (pt_x == $past(sum_x_chk[DATA_W:1]) && pt_y == $past(sum_y_chk[DATA_W:1])));
   p_equal_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && rd_xm == rd_xp && rd_ym == rd_yp) |=> pt_vld);
   p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && (far_x || far_y)) |=> !pt_vld);
   p_x_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && far_x && drop_cnt != CMAX) |=> drop_cnt == $past(drop_cnt) + 1'b1);
   p_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pt_vld |-> pt_za == $past(rd_za));
   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt == CMAX) |=> drop_cnt == CMAX);
   p_count_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> $stable(drop_cnt));
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> (!pt_vld && $stable(pt_x) && $stable(pt_y) && $stable(pt_za)));
endmodule

bind touch_pair_avg tpa_checker #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) i_tpa_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_vld (frame_vld),
   .rd_xm     (rd_xm),
   .rd_xp     (rd_xp),
   .rd_ym     (rd_ym),
   .rd_yp     (rd_yp),
   .rd_za     (rd_za),
   .far_x     (far_x),
   .far_y     (far_y),
   .pt_vld    (pt_vld),
   .pt_x      (pt_x),
   .pt_y      (pt_y),
   .pt_za     (pt_za),
   .drop_cnt  (drop_cnt)
);

// File: tb/test_touch_pair_avg.sv
`timescale 1ns/1ps
module test_touch_pair_avg;
   localparam int DW   = 12;
   localparam int CW   = 16;
   localparam int CMAX = 65535;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_vld = 1'b0;
   logic [DW-1:0] rd_xm = '0, rd_xp = '0, rd_ym = '0, rd_yp = '0;
   logic [DW-1:0] rd_za = '0, rd_zb = '0, scatter_thr = '0;
   logic          pt_vld;
   logic [DW-1:0] pt_x, pt_y, pt_za, pt_zb;
   logic [CW-1:0] drop_cnt;

   always #2 clk = ~clk;

   touch_pair_avg i_touch_pair_avg (
      .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
      .rd_xm(rd_xm), .rd_xp(rd_xp), .rd_ym(rd_ym), .rd_yp(rd_yp),
      .rd_za(rd_za), .rd_zb(rd_zb), .scatter_thr(scatter_thr),
      .pt_vld(pt_vld), .pt_x(pt_x), .pt_y(pt_y), .pt_za(pt_za), .pt_zb(pt_zb),
      .drop_cnt(drop_cnt));

   typedef struct {
      bit    vld;
      int    x, y, za, zb;
      string tag;
   } exp_t;

   exp_t  sb[$];
   exp_t  cur;
   int    n_checks = 0;
   int    n_errors = 0;
   int    model_drop = 0;
   bit    fv_d = 1'b0;
   bit    done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv,
                      input string what);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   function automatic bit pair_far(input int m, input int p, input int t);
      if (m > p) return m > p + t;
      return p > m + t;
   endfunction

   task automatic send(input int xm, input int xp, input int ym, input int yp,
                       input int za, input int zb, input int thr, input string tag);
      exp_t e;
      e.vld = !pair_far(xm, xp, thr) && !pair_far(ym, yp, thr);
      e.x = (xm + xp) / 2;
      e.y = (ym + yp) / 2;
      e.za = za;
      e.zb = zb;
      e.tag = tag;
      @(negedge clk);
      sb.push_back(e);
      rd_xm = DW'(xm); rd_xp = DW'(xp); rd_ym = DW'(ym); rd_yp = DW'(yp);
      rd_za = DW'(za); rd_zb = DW'(zb); scatter_thr = DW'(thr);
      frame_vld = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_vld = 1'b0;
      end
   endtask

   always @(posedge clk) fv_d <= frame_vld;

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (fv_d) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R2", int'(pt_vld), 0, "result without frame");
            end else begin
               cur = sb.pop_front();
               if (!cur.vld && model_drop != CMAX) model_drop++;
               chk(pt_vld == cur.vld, cur.tag, int'(pt_vld), int'(cur.vld), "pt_vld");
               if (cur.vld) begin
                  chk(int'(pt_x) == cur.x, cur.tag, int'(pt_x), cur.x, "pt_x");
                  chk(int'(pt_y) == cur.y, cur.tag, int'(pt_y), cur.y, "pt_y");
                  chk(int'(pt_za) == cur.za, "R7", int'(pt_za), cur.za, "pt_za");
                  chk(int'(pt_zb) == cur.zb, "R7", int'(pt_zb), cur.zb, "pt_zb");
               end
               chk(int'(drop_cnt) == model_drop, "R8", int'(drop_cnt), model_drop, "drop_cnt");
            end
         end else begin
            chk(pt_vld == 1'b0, "R9", int'(pt_vld), 0, "pt_vld idle");
         end
      end
   end

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int hx, hy, hza;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pt_vld == 1'b0, "R1", int'(pt_vld), 0, "pt_vld in reset");
      chk(drop_cnt == '0, "R1", int'(drop_cnt), 0, "drop_cnt in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(pt_x == '0 && pt_y == '0, "R1", int'(pt_x), 0, "pt_x after reset");

      send(1000, 1010, 2000, 1990, 7, 9, 16, "R2");
      send(333, 333, 4000, 4000, 1, 2, 0, "R4");
      send(500, 520, 700, 680, 3, 4, 20, "R3");
      send(500, 521, 700, 700, 3, 4, 20, "R3");
      send(500, 500, 700, 721, 3, 4, 20, "R5");
      send(100, 900, 50, 50, 3, 4, 10, "R6");
      send(100, 900, 50, 900, 3, 4, 10, "R6");
      send(4095, 4095, 4095, 4094, 11, 12, 1, "R10");
      send(0, 1, 1, 0, 4095, 0, 1, "R2");
      idle(1);
      send(1234, 1240, 2222, 2230, 321, 654, 8, "R7");
      idle(1);
      hx = int'(pt_x); hy = int'(pt_y); hza = int'(pt_za);
      idle(3);
      // R9 outputs held with no frame
      chk(int'(pt_x) == hx, "R9", int'(pt_x), hx, "pt_x hold");
      chk(int'(pt_y) == hy, "R9", int'(pt_y), hy, "pt_y hold");
      chk(int'(pt_za) == hza, "R9", int'(pt_za), hza, "pt_za hold");
      for (int i = 0; i < 16; i++)
         send(i * 200, i * 200 + (i % 5), 4095 - i * 100, 4095 - i * 100 - (i % 3), i, 2 * i, 3, "R2");
      // R8 saturation at 65535
      for (int i = 0; i < CMAX + 5; i++)
         send(0, 100, 0, 0, 0, 0, 0, "R8");
      idle(2);
      chk(int'(drop_cnt) == CMAX, "R8", int'(drop_cnt), CMAX, "drop_cnt saturated");
      send(10, 10, 20, 20, 5, 6, 0, "R4");
      idle(2);
      chk(sb.size() == 0, "R2", sb.size(), 0, "scoreboard drained");
      done = 1'b1;
      finish_run();
   end
endmodule